// File: doc/BRIEF.md
# ADC Result Register Bank

This block holds the conversion results of a multi-channel analog-to-digital converter controller. It has one result register for each channel in two groups of 32: the internal group at channel indices 32 to 63 and the external group at indices 64 to 95. The conversion side presents a channel index, a 10-bit sample and a 2-bit tag that names the kind of conversion that produced the sample. The bus side reads one channel per access and receives a 32-bit word that packs the sample, the tag and two status flags.

A fresh-data flag tells software that a channel holds a result it has not yet read. A sticky flag records that a result arrived while the previous one was still unread. Both flags clear when the channel is read. A single policy input decides what happens to that late result: it either replaces the stored data or is dropped so that the old data stays.

Top module: `adc_result_bank`

## Requirements
- R1: Each channel index from 32 to 95 has its own register, and the boundary indices 32, 63, 64 and 95 are all addressable. A conversion write to an index outside 32..95 changes no register.
- R2: A conversion write to a channel that holds no unread result stores the sample and the tag and sets the fresh flag.
- R3: A bus read of a channel clears both its fresh flag and its overwrite flag, and the stored sample and tag are kept. A second read returns the same data with both flags at zero.
- R4: A conversion write to a channel whose fresh flag is set also sets that channel's overwrite flag, whatever the policy input is.
- R5: When `ovwr_en_i` is 1, a write to a channel with an unread result replaces the stored sample and tag.
- R6: When `ovwr_en_i` is 0, a write to a channel with an unread result is dropped and the old sample and tag stay.
- R7: The read word has the fresh flag in bit 19, the overwrite flag in bit 18, the tag in bits 17:16 and the sample in bits 9:0. Every other bit is 0. Tag codes are 00 normal, 01 injected and 10 hardware-triggered. Code 11 is reserved and is stored and returned unchanged.
- R8: Synchronous reset clears every register field and the read output to zero.
- R9: If a bus read and a conversion write address the same channel in the same cycle, the read returns the word as it was before that cycle. The write is then stored, with the fresh flag set and the overwrite flag at 0, whatever the policy input is.
- R10: The read word appears on `rd_data_o` one clock after the access. It holds its value in cycles with no bus access.
- R11: A bus read of an index outside 32..95 returns zero and changes no register.
- R12: A bus access with `bus_we_i` set changes no register, leaves all flags untouched and returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ovwr_en_i | input | 1 | Policy input: 1 replaces an unread result, 0 drops the new result |
| cv_wr_i | input | 1 | Conversion result strobe |
| cv_ch_i | input | 7 | Channel index of the conversion result |
| cv_data_i | input | 10 | Converted sample |
| cv_mode_i | input | 2 | Conversion kind tag |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Bus write strobe (the access is ignored) |
| bus_ch_i | input | 7 | Channel index of the bus access |
| rd_data_o | output | 32 | Registered read word |

## Verification
The assertions check four rules on every cycle: the word layout keeps its unused bits at zero, a set overwrite flag never appears without the fresh flag, out-of-range reads and write-strobe accesses return zero, and the output holds between accesses. They also check that a read which directly follows a read of the same channel, with no write in between, shows the fresh flag cleared. The bench's scenarios are needed for the rest. They show the two results of the replace-or-drop policy, the data kept after a read, that ignored accesses leave stored state untouched, and the outcome of a read and a write that collide on one channel. A behavioural model of all 64 channels follows every cycle and backs these scenarios.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;

    localparam int CH_IDX_W  = 7;
    localparam int SAMPLE_W  = 10;
    localparam int WORD_W    = 32;
    localparam int CH_FIRST  = 32;
    localparam int GROUP_SZ  = 32;
    localparam int GROUP_CNT = 2;
    localparam int CH_LAST   = CH_FIRST + GROUP_SZ * GROUP_CNT - 1;

    // bit positions of the read word, fixed by what software decodes
    localparam int POS_FRESH = 19;
    localparam int POS_OVERW = 18;
    localparam int POS_TAG   = 16;

    typedef enum logic [1:0] {
        TAG_NORMAL   = 2'b00,
        TAG_INJECTED = 2'b01,
        TAG_TRIGGER  = 2'b10,
        TAG_RESERVED = 2'b11
    } conv_tag_e;

    typedef struct packed {
        logic                fresh;
        logic                overw;
        conv_tag_e           tag;
        logic [SAMPLE_W-1:0] sample;
    } slot_t;

    typedef struct packed {
        conv_tag_e           tag;
        logic [SAMPLE_W-1:0] sample;
    } result_t;

    function automatic logic [WORD_W-1:0] pack_word(slot_t s);
        logic [WORD_W-1:0] w;
        w                       = '0;
        w[POS_FRESH]            = s.fresh;
        w[POS_OVERW]            = s.overw;
        w[POS_TAG +: 2]         = s.tag;
        w[SAMPLE_W-1:0]         = s.sample;
        return w;
    endfunction

    function automatic logic idx_in_window(logic [CH_IDX_W-1:0] idx);
        return (idx >= CH_IDX_W'(CH_FIRST)) && (idx <= CH_IDX_W'(CH_LAST));
    endfunction

endpackage

// File: rtl/adc_rb_decode.sv
module adc_rb_decode
    import adc_result_pkg::*;
#(
    parameter int IDX_W   = CH_IDX_W,
    parameter int BASE    = CH_FIRST,
    parameter int COUNT   = GROUP_SZ * GROUP_CNT,
    localparam int OFF_W  = $clog2(COUNT)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             hit_o,
    output logic [OFF_W-1:0] off_o
);
    localparam logic [IDX_W-1:0] LO = IDX_W'(BASE);
    localparam logic [IDX_W-1:0] HI = IDX_W'(BASE + COUNT - 1);

    logic [IDX_W-1:0] diff;

    always_comb begin
        hit_o = (idx_i >= LO) && (idx_i <= HI);
        diff  = idx_i - LO;
        off_o = OFF_W'(diff);
    end
endmodule

// File: rtl/adc_rb_slot.sv
module adc_rb_slot
    import adc_result_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    ovwr_en_i,
    input  logic    wr_hit_i,
    input  result_t wr_res_i,
    input  logic    rd_hit_i,
    output slot_t   slot_o
);
    slot_t cur;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur <= '0;
        end else if (wr_hit_i) begin
            if (rd_hit_i || !cur.fresh) begin
                // slot is empty, or the same-cycle read has consumed it
                cur.fresh  <= 1'b1;
                cur.overw  <= rd_hit_i ? 1'b0 : cur.overw;
                cur.tag    <= wr_res_i.tag;
                cur.sample <= wr_res_i.sample;
            end else begin
                cur.overw <= 1'b1;
                if (ovwr_en_i) begin
                    cur.tag    <= wr_res_i.tag;
                    cur.sample <= wr_res_i.sample;
                end
            end
        end else if (rd_hit_i) begin
            cur.fresh <= 1'b0;
            cur.overw <= 1'b0;
        end
    end

    assign slot_o = cur;
endmodule

// File: rtl/adc_rb_rdmux.sv
module adc_rb_rdmux
    import adc_result_pkg::*;
#(
    parameter int COUNT  = GROUP_SZ * GROUP_CNT,
    localparam int OFF_W = $clog2(COUNT)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              acc_i,
    input  logic              rd_hit_i,
    input  logic [OFF_W-1:0]  off_i,
    input  slot_t             slots_i [COUNT],
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sel_word;
    logic [WORD_W-1:0] q;

    always_comb begin
        sel_word = '0;
        if (rd_hit_i) begin
            sel_word = pack_word(slots_i[off_i]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
        end else if (acc_i) begin
            q <= sel_word;
        end
    end

    assign word_o = q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_result_pkg::*;
#(
    parameter int BASE_CH  = CH_FIRST,
    parameter int GRP_SZ   = GROUP_SZ,
    parameter int GRP_CNT  = GROUP_CNT,
    localparam int CH_CNT  = GRP_SZ * GRP_CNT,
    localparam int OFF_W   = $clog2(CH_CNT)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                ovwr_en_i,
    input  logic                cv_wr_i,
    input  logic [CH_IDX_W-1:0] cv_ch_i,
    input  logic [SAMPLE_W-1:0] cv_data_i,
    input  logic [1:0]          cv_mode_i,
    input  logic                bus_sel_i,
    input  logic                bus_we_i,
    input  logic [CH_IDX_W-1:0] bus_ch_i,
    output logic [WORD_W-1:0]   rd_data_o
);
    logic             wr_in, bus_in;
    logic [OFF_W-1:0] wr_off, bus_off;
    logic             rd_hit;
    logic [CH_CNT-1:0] wr_sel, rd_sel;
    result_t          new_res;
    slot_t            slots [CH_CNT];

    adc_rb_decode #(.IDX_W(CH_IDX_W), .BASE(BASE_CH), .COUNT(CH_CNT)) u_wr_dec (
        .idx_i (cv_ch_i),
        .hit_o (wr_in),
        .off_o (wr_off)
    );

    adc_rb_decode #(.IDX_W(CH_IDX_W), .BASE(BASE_CH), .COUNT(CH_CNT)) u_bus_dec (
        .idx_i (bus_ch_i),
        .hit_o (bus_in),
        .off_o (bus_off)
    );

    always_comb begin
        rd_hit         = bus_sel_i && !bus_we_i && bus_in;
        new_res.tag    = conv_tag_e'(cv_mode_i);
        new_res.sample = cv_data_i;
        wr_sel         = (cv_wr_i && wr_in) ? (CH_CNT'(1) << wr_off) : '0;
        rd_sel         = rd_hit ? (CH_CNT'(1) << bus_off) : '0;
    end

    for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
        for (genvar c = 0; c < GRP_SZ; c++) begin : g_ch
            localparam int K = g * GRP_SZ + c;
            adc_rb_slot u_slot (
                .clk_i     (clk_i),
                .rst_i     (rst_i),
                .ovwr_en_i (ovwr_en_i),
                .wr_hit_i  (wr_sel[K]),
                .wr_res_i  (new_res),
                .rd_hit_i  (rd_sel[K]),
                .slot_o    (slots[K])
            );
        end
    end

    adc_rb_rdmux #(.COUNT(CH_CNT)) u_rdmux (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .acc_i    (bus_sel_i),
        .rd_hit_i (rd_hit),
        .off_i    (bus_off),
        .slots_i  (slots),
        .word_o   (rd_data_o)
    );
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk
    import adc_result_pkg::*;
(
    input logic                clk_i,
    input logic                rst_i,
    input logic                ovwr_en_i,
    input logic                cv_wr_i,
    input logic [CH_IDX_W-1:0] cv_ch_i,
    input logic [SAMPLE_W-1:0] cv_data_i,
    input logic [1:0]          cv_mode_i,
    input logic                bus_sel_i,
    input logic                bus_we_i,
    input logic [CH_IDX_W-1:0] bus_ch_i,
    input logic [WORD_W-1:0]   rd_data_o
);
    logic rd_ok;
    assign rd_ok = bus_sel_i && !bus_we_i && idx_in_window(bus_ch_i);

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> rd_data_o == '0);  // R8

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_data_o[WORD_W-1:POS_FRESH+1] == '0) && (rd_data_o[POS_TAG-1:SAMPLE_W] == '0));  // R7

    AST_OVERW_NEEDS_FRESH: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_data_o[POS_OVERW] |-> rd_data_o[POS_FRESH]);  // R4

    AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_sel_i && !bus_we_i && !idx_in_window(bus_ch_i)) |=> rd_data_o == '0);  // R11

    AST_WRITE_ACCESS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_sel_i && bus_we_i) |=> rd_data_o == '0);  // R12

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_sel_i |=> $stable(rd_data_o));  // R10

    AST_REREAD_NOT_FRESH: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_ok && $past(rd_ok) && !$past(rst_i) && (bus_ch_i == $past(bus_ch_i))
         && !($past(cv_wr_i) && ($past(cv_ch_i) == bus_ch_i)))
        |=> !rd_data_o[POS_FRESH] && !rd_data_o[POS_OVERW]);  // R3
endmodule

bind adc_result_bank adc_result_bank_chk u_chk (.*);

// File: tb/adc_result_bank_tb.sv
`timescale 1ns/1ps
module adc_result_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ovwr_en = 1'b0;
    logic        cv_wr = 1'b0;
    logic [6:0]  cv_ch = '0;
    logic [9:0]  cv_data = '0;
    logic [1:0]  cv_mode = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_ch = '0;
    logic [31:0] rd_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    adc_result_bank u_dut (
        .clk_i(clk), .rst_i(rst), .ovwr_en_i(ovwr_en),
        .cv_wr_i(cv_wr), .cv_ch_i(cv_ch), .cv_data_i(cv_data), .cv_mode_i(cv_mode),
        .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_ch_i(bus_ch),
        .rd_data_o(rd_data)
    );

    // behavioural reference: one entry per channel index, indexed directly
    int m_fresh [128];
    int m_overw [128];
    int m_tag   [128];
    int m_smp   [128];
    logic [31:0] exp_rd = '0;

    function automatic logic [31:0] mk(int f, int o, int t, int s);
        return 32'(f * (1 << 19) + o * (1 << 18) + t * (1 << 16) + s);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) begin
                m_fresh[i] = 0; m_overw[i] = 0; m_tag[i] = 0; m_smp[i] = 0;
            end
            exp_rd = '0;
        end else begin
            int  bc, wc;
            bit  rd_ok, wr_ok;
            bc    = int'(bus_ch);
            wc    = int'(cv_ch);
            rd_ok = bus_sel && !bus_we && bc >= 32 && bc <= 95;
            wr_ok = cv_wr && wc >= 32 && wc <= 95;
            if (bus_sel)
                exp_rd = rd_ok ? mk(m_fresh[bc], m_overw[bc], m_tag[bc], m_smp[bc]) : '0;
            if (rd_ok) begin
                m_fresh[bc] = 0;
                m_overw[bc] = 0;
            end
            if (wr_ok) begin
                if (m_fresh[wc] != 0) begin
                    m_overw[wc] = 1;
                    if (ovwr_en) begin
                        m_tag[wc] = int'(cv_mode);
                        m_smp[wc] = int'(cv_data);
                    end
                end else begin
                    m_fresh[wc] = 1;
                    m_tag[wc]   = int'(cv_mode);
                    m_smp[wc]   = int'(cv_data);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model (R10 timing, all fields)
    always @(negedge clk) begin
        if (!rst && !done) chk("R10 model compare", rd_data, exp_rd);
    end

    task automatic step(input bit w, input int wc, input int wd, input int wm,
                        input bit s, input bit we, input int bc);
        cv_wr = w; cv_ch = 7'(wc); cv_data = 10'(wd); cv_mode = 2'(wm);
        bus_sel = s; bus_we = we; bus_ch = 7'(bc);
        @(posedge clk);
        @(negedge clk);
        cv_wr = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input int ch, input int d, input int m);
        step(1'b1, ch, d, m, 1'b0, 1'b0, 0);
    endtask

    task automatic rd(input int ch);
        step(1'b0, 0, 0, 0, 1'b1, 1'b0, ch);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 output after reset", rd_data, 32'h0);
        rd(40);
        chk("R8 register cleared by reset", rd_data, 32'h0);

        wr(33, 'h2A5, 1);
        rd(33);
        chk("R2 fresh write readback", rd_data, mk(1, 0, 1, 'h2A5));
        chk("R7 unused bits zero", rd_data & 32'hFFF0_FC00, 32'h0);
        rd(33);
        chk("R3 reread flags cleared data kept", rd_data, mk(0, 0, 1, 'h2A5));

        ovwr_en = 1'b0;
        wr(64, 'h100, 0);
        wr(64, 'h3FF, 2);
        rd(64);
        chk("R4 R6 drop keeps old data, overwrite flag set", rd_data, mk(1, 1, 0, 'h100));
        rd(64);
        chk("R3 read clears overwrite flag", rd_data, mk(0, 0, 0, 'h100));

        ovwr_en = 1'b1;
        wr(95, 'h011, 0);
        wr(95, 'h022, 2);
        rd(95);
        chk("R5 replace policy stores newer result", rd_data, mk(1, 1, 2, 'h022));

        wr(31, 'h155, 1);
        wr(96, 'h155, 1);
        rd(32);
        chk("R1 out-of-range write leaves ch32 empty", rd_data, 32'h0);
        rd(31);
        chk("R11 read below window", rd_data, 32'h0);
        rd(96);
        chk("R11 read above window", rd_data, 32'h0);
        wr(63, 'h3FF, 2);
        rd(63);
        chk("R1 last internal channel", rd_data, mk(1, 0, 2, 'h3FF));

        wr(50, 'h0AB, 3);
        rd(120);
        chk("R11 out-of-range read returns zero", rd_data, 32'h0);
        rd(50);
        chk("R11 R7 state kept, reserved tag stored", rd_data, mk(1, 0, 3, 'h0AB));

        wr(51, 'h0CD, 0);
        step(1'b0, 0, 0, 0, 1'b1, 1'b1, 51);
        chk("R12 write access returns zero", rd_data, 32'h0);
        rd(51);
        chk("R12 write access left flags", rd_data, mk(1, 0, 0, 'h0CD));

        ovwr_en = 1'b0;
        wr(70, 'h00A, 0);
        step(1'b1, 70, 'h00B, 1, 1'b1, 1'b0, 70);
        chk("R9 collision read sees old word", rd_data, mk(1, 0, 0, 'h00A));
        rd(70);
        chk("R9 collision write stored, no overwrite", rd_data, mk(1, 0, 1, 'h00B));
        step(1'b0, 0, 0, 0, 1'b0, 1'b0, 0);
        step(1'b0, 0, 0, 0, 1'b0, 1'b0, 0);
        chk("R10 output holds while idle", rd_data, mk(1, 0, 1, 'h00B));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule